// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the register-mapped face of one serial channel. A host reaches it through a simple single-cycle bus port that carries a valid flag, a write flag, a byte offset and 32-bit data. Six word registers sit behind that port: transmit data, receive data, control, status, interrupt levels and baud word. Characters that the host writes go into a 64-entry transmit queue. A small feed state machine hands them to the serial framing engine through a valid/ready pair. Characters that the framing engine delivers go into a 64-entry receive queue, and the host pops them by reading the receive data register.

The block also keeps sticky error flags for parity, framing and write-while-full. It honours level-held software resets and a level-held error clear, and it drives a single interrupt line from two programmable fill levels. The full control word and the baud word leave the block unchanged, so that the framing engine and the baud tick generator can decode their own fields. Modem-control lines are not present; the clear-to-send line is taken as always active.

The transmit feed machine has three states. FEED_OFF means the transmitter is disabled or its reset is held. FEED_IDLE means it is enabled with nothing queued. FEED_SEND means a character is being offered. Its transitions are:
- enable: FEED_OFF to FEED_IDLE, or to FEED_SEND if data is queued
- fill: FEED_IDLE to FEED_SEND
- drain: FEED_SEND to FEED_IDLE when the last character is taken
- halt: any state to FEED_OFF when the enable drops or the reset is held

Top module: `uart_regfront`

## Requirements
- R1: Byte offsets decode as follows: 0x00 transmit data, 0x04 receive data, 0x08 control, 0x0C status, 0x10 levels, 0x14 baud. Control and baud read back the full word last written. The levels register keeps and returns bits 15:0, and reads zero above them. Reading 0x00, or any offset not in the map, returns zero.
- R2: While control bit 12 is 1 and bit 22 is 0, queued characters are offered on `tx_data` in write order. A character leaves the queue in a cycle where `tx_valid` and `tx_ready` are both 1.
- R3: A write to 0x00 while the transmit queue holds 64 entries is dropped and sets status bit 18. A transmit queue that is full at the start of a cycle takes no write in that cycle, even if a character leaves in the same cycle.
- R4: While control bit 22 is 1, the transmit queue is empty and writes to 0x00 are discarded. While control bit 23 is 1, the receive queue is empty and arriving characters are discarded. Normal operation resumes when software writes the bit back to 0.
- R5: While control bit 24 is 1, status bits 16, 17 and 18 read 0, and a clear wins over a new error in the same cycle. Errors latch again once the bit returns to 0.
- R6: A character on `rx_valid` is taken only while control bit 13 is 1 (and bit 23 is 0). A taken character sets status bit 16 when it carries a parity error and bit 17 when it carries a framing error. When the receive queue is full, a taken character is dropped.
- R7: Reading 0x04 returns the oldest received character in bits 7:0, with zeros above, and removes it from the queue. Reading 0x04 with the receive queue empty returns zero and changes nothing.
- R8: Status bit 20 is 1 when the receive queue is empty, bit 21 when the transmit queue is full, and bit 22 when the transmit queue is empty. Bit 25 mirrors `tx_busy`. All other status bits read 0.
- R9: `irq` is 1 when control bit 27 is 1 and the receive count is at least levels bits 7:0.
- R10: `irq` is 1 when control bit 28 is 1 and the transmit count is at most levels bits 15:8. It is 0 when neither this condition nor R9 holds.
- R11: `tx_valid` is 1 exactly when the feed machine is in FEED_SEND. It becomes 1 the cycle after the transmitter is enabled with data queued, and 0 the cycle after the enable drops or the reset is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| tx_valid | output | 1 | Character offered to the framing engine |
| tx_ready | input | 1 | Framing engine takes the offered character |
| tx_data | output | 8 | Offered character |
| tx_busy | input | 1 | Transmit shifter busy |
| rx_valid | input | 1 | Framing engine delivers a character |
| rx_data | input | 8 | Delivered character |
| rx_par_err | input | 1 | Delivered character had a parity error |
| rx_frm_err | input | 1 | Delivered character had a framing error |
| ctrl_word | output | 32 | Current control word |
| baud_word | output | 32 | Current baud word |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a bus read of the receive register and a character arriving from the line, at a full queue, at an empty queue and in between. The second pair is a host write to the transmit register and the framing engine taking a character, including a write to a full queue. The bench provokes both by driving the bus and the serial side together in the same cycle. It judges them against a queue-based model that applies the rule "fullness and emptiness are taken at the start of the cycle". A held error clear that meets a fresh parity error is provoked the same way, and the status word must show the clear winning.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_TXD  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RXD  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STA  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_LVL  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_BAUD = 5'h14;

    // control word bit positions
    localparam int CTL_TX_ON   = 12;
    localparam int CTL_RX_ON   = 13;
    localparam int CTL_TX_HOLD = 22;
    localparam int CTL_RX_HOLD = 23;
    localparam int CTL_WIPE    = 24;
    localparam int CTL_RX_IE   = 27;
    localparam int CTL_TX_IE   = 28;

    // status word bit positions
    localparam int STA_PAR     = 16;
    localparam int STA_FRM     = 17;
    localparam int STA_OVW     = 18;
    localparam int STA_RX_NONE = 20;
    localparam int STA_TX_FULL = 21;
    localparam int STA_TX_NONE = 22;
    localparam int STA_SHIFT   = 25;

    typedef enum logic [1:0] {
        FEED_OFF,
        FEED_IDLE,
        FEED_SEND
    } feed_state_e;
endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic                         pop,
    input  logic [WIDTH-1:0]             din,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [$clog2(DEPTH+1)-1:0]   count_nxt,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign dout    = mem[rptr];

    always_comb begin
        if (flush)
            count_nxt = '0;
        else
            count_nxt = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok)
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop_ok)
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            count <= count_nxt;
        end
    end

    // R3: the queue never holds more than its depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R4: a held flush leaves the queue empty on the next cycle
    a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/uart_rf_txfeed.sv
module uart_rf_txfeed import uart_rf_pkg::*; #(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              hold,
    input  logic [CNT_W-1:0]  fill_nxt,
    output logic              offer,
    output feed_state_e       state
);
    feed_state_e state_nxt;
    logic        halt;
    logic        has_data;

    assign halt     = !enable || hold;
    assign has_data = (fill_nxt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= FEED_OFF;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            FEED_OFF: begin
                if (!halt)
                    state_nxt = has_data ? FEED_SEND : FEED_IDLE;
            end
            FEED_IDLE: begin
                if (halt)
                    state_nxt = FEED_OFF;
                else if (has_data)
                    state_nxt = FEED_SEND;
            end
            FEED_SEND: begin
                if (halt)
                    state_nxt = FEED_OFF;
                else if (!has_data)
                    state_nxt = FEED_IDLE;
            end
            default: state_nxt = FEED_OFF;
        endcase
    end

    always_comb begin
        offer = 1'b0;
        unique case (state)
            FEED_OFF:  offer = 1'b0;
            FEED_IDLE: offer = 1'b0;
            FEED_SEND: offer = 1'b1;
            default:   offer = 1'b0;
        endcase
    end

    // R11: dropping the enable or raising the hold stops the offer next cycle
    a_r11_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (state == FEED_OFF));
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront import uart_rf_pkg::*; #(
    parameter int DATA_W   = 32,
    parameter int CHAR_W   = 8,
    parameter int TX_DEPTH = 64,
    parameter int RX_DEPTH = 64,
    parameter int LVL_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_busy,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] baud_word,
    output logic              irq
);
    localparam int TX_CNT_W = $clog2(TX_DEPTH+1);
    localparam int RX_CNT_W = $clog2(RX_DEPTH+1);
    localparam int LVL_REG  = 2 * LVL_W;
    localparam int CMP_W    = TX_CNT_W + RX_CNT_W + LVL_W;

    logic [DATA_W-1:0]  ctrl_q, baud_q;
    logic [LVL_REG-1:0] lvl_q;
    logic               par_q, frm_q, ovw_q;

    logic wr_any, rd_any, wr_txd, rd_rxd;
    logic tx_pop, ovw_set, rx_take;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [TX_CNT_W-1:0] tx_cnt, tx_cnt_nxt;
    logic [RX_CNT_W-1:0] rx_cnt, rx_cnt_nxt;
    logic [CHAR_W-1:0]   rx_head;
    logic [DATA_W-1:0]   status;
    logic rx_hit, tx_hit;
    feed_state_e feed_state;

    assign wr_any  = bus_valid && bus_write;
    assign rd_any  = bus_valid && !bus_write;
    assign wr_txd  = wr_any && (bus_addr == OFS_TXD);
    assign rd_rxd  = rd_any && (bus_addr == OFS_RXD);
    assign tx_pop  = tx_valid && tx_ready;
    assign ovw_set = wr_txd && tx_full && !ctrl_q[CTL_TX_HOLD];
    assign rx_take = rx_valid && ctrl_q[CTL_RX_ON] && !ctrl_q[CTL_RX_HOLD];

    uart_rf_fifo #(.WIDTH(CHAR_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(ctrl_q[CTL_TX_HOLD]),
        .push(wr_txd), .pop(tx_pop), .din(bus_wdata[CHAR_W-1:0]),
        .dout(tx_data), .count(tx_cnt), .count_nxt(tx_cnt_nxt),
        .full(tx_full), .empty(tx_empty)
    );

    uart_rf_fifo #(.WIDTH(CHAR_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(ctrl_q[CTL_RX_HOLD]),
        .push(rx_take), .pop(rd_rxd), .din(rx_data),
        .dout(rx_head), .count(rx_cnt), .count_nxt(rx_cnt_nxt),
        .full(rx_full), .empty(rx_empty)
    );

    uart_rf_txfeed #(.CNT_W(TX_CNT_W)) u_feed (
        .clk(clk), .rst_n(rst_n),
        .enable(ctrl_q[CTL_TX_ON]), .hold(ctrl_q[CTL_TX_HOLD]),
        .fill_nxt(tx_cnt_nxt), .offer(tx_valid), .state(feed_state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            baud_q <= '0;
            lvl_q  <= '0;
            par_q  <= 1'b0;
            frm_q  <= 1'b0;
            ovw_q  <= 1'b0;
        end else begin
            if (ctrl_q[CTL_WIPE]) begin
                par_q <= 1'b0;
                frm_q <= 1'b0;
                ovw_q <= 1'b0;
            end else begin
                par_q <= par_q || (rx_take && rx_par_err);
                frm_q <= frm_q || (rx_take && rx_frm_err);
                ovw_q <= ovw_q || ovw_set;
            end
            if (wr_any && (bus_addr == OFS_CTL))
                ctrl_q <= bus_wdata;
            if (wr_any && (bus_addr == OFS_LVL))
                lvl_q <= bus_wdata[LVL_REG-1:0];
            if (wr_any && (bus_addr == OFS_BAUD))
                baud_q <= bus_wdata;
        end
    end

    always_comb begin
        status              = '0;
        status[STA_PAR]     = par_q;
        status[STA_FRM]     = frm_q;
        status[STA_OVW]     = ovw_q;
        status[STA_RX_NONE] = rx_empty;
        status[STA_TX_FULL] = tx_full;
        status[STA_TX_NONE] = tx_empty;
        status[STA_SHIFT]   = tx_busy;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_any) begin
            case (bus_addr)
                OFS_RXD:  bus_rdata = rx_empty ? '0 : DATA_W'(rx_head);
                OFS_CTL:  bus_rdata = ctrl_q;
                OFS_STA:  bus_rdata = status;
                OFS_LVL:  bus_rdata = DATA_W'(lvl_q);
                OFS_BAUD: bus_rdata = baud_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign rx_hit = ctrl_q[CTL_RX_IE] &&
                    (CMP_W'(rx_cnt) >= CMP_W'(lvl_q[LVL_W-1:0]));
    assign tx_hit = ctrl_q[CTL_TX_IE] &&
                    (CMP_W'(tx_cnt) <= CMP_W'(lvl_q[LVL_REG-1:LVL_W]));
    assign irq       = rx_hit || tx_hit;
    assign ctrl_word = ctrl_q;
    assign baud_word = baud_q;

    // R2: an offer is only made while the transmit queue holds data
    a_r2_offer_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !tx_empty);
    // R3: a write to a full queue without a held clear leaves the overwrite flag set
    a_r3_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txd && tx_full && !ctrl_q[CTL_TX_HOLD] && !ctrl_q[CTL_WIPE]) |=> ovw_q);
    // R5: a held clear empties every error flag by the next cycle
    a_r5_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTL_WIPE] |=> !(par_q || frm_q || ovw_q));
    // R6: a character is never taken while reception is off
    a_r6_rx_off_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CTL_RX_ON] && !rd_rxd) |=> (rx_cnt <= $past(rx_cnt)));
    // R11: the offer follows the feed state
    a_r11_offer_state: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid == (feed_state == FEED_SEND));
endmodule

// File: tb/sim_uart_regfront.sv
module sim_uart_regfront;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_write;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        tx_valid, tx_ready, tx_busy;
    logic [7:0]  tx_data;
    logic        rx_valid, rx_par_err, rx_frm_err;
    logic [7:0]  rx_data;
    logic [31:0] ctrl_word, baud_word;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];
    logic [31:0] m_ctrl = '0, m_baud = '0;
    logic [15:0] m_lvl = '0;
    logic        m_par = 0, m_frm = 0, m_ovw = 0, m_send = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regfront u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .ctrl_word(ctrl_word), .baud_word(baud_word), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[16] = m_par; s[17] = m_frm; s[18] = m_ovw;
        s[20] = (rxq.size() == 0);
        s[21] = (txq.size() == 64);
        s[22] = (txq.size() == 0);
        s[25] = tx_busy;
        return s;
    endfunction

    function automatic logic [31:0] exp_read(logic [4:0] a);
        case (a)
            5'h04:   return (rxq.size() != 0) ? {24'h0, rxq[0]} : 32'h0;
            5'h08:   return m_ctrl;
            5'h0C:   return exp_status();
            5'h10:   return {16'h0, m_lvl};
            5'h14:   return m_baud;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_update();
        logic [31:0] oc = m_ctrl;
        logic wr = bus_valid && bus_write;
        logic rd = bus_valid && !bus_write;
        logic txfull0 = (txq.size() == 64);
        logic rxfull0 = (rxq.size() == 64);
        logic rxempty0 = (rxq.size() == 0);
        logic ovw_set = 0, par_set = 0, frm_set = 0, take;
        if (m_send && tx_ready) void'(txq.pop_front());
        if (wr && bus_addr == 5'h00 && !oc[22]) begin
            if (txfull0) ovw_set = 1;
            else txq.push_back(bus_wdata[7:0]);
        end
        if (oc[22]) txq.delete();
        take = rx_valid && oc[13] && !oc[23];
        if (rd && bus_addr == 5'h04 && !rxempty0) void'(rxq.pop_front());
        if (take) begin
            par_set = rx_par_err;
            frm_set = rx_frm_err;
            if (!rxfull0) rxq.push_back(rx_data);
        end
        if (oc[23]) rxq.delete();
        m_par = oc[24] ? 1'b0 : (m_par | par_set);
        m_frm = oc[24] ? 1'b0 : (m_frm | frm_set);
        m_ovw = oc[24] ? 1'b0 : (m_ovw | ovw_set);
        if (wr && bus_addr == 5'h08) m_ctrl = bus_wdata;
        if (wr && bus_addr == 5'h10) m_lvl = bus_wdata[15:0];
        if (wr && bus_addr == 5'h14) m_baud = bus_wdata;
        m_send = oc[12] && !oc[22] && (txq.size() > 0);
    endtask

    // compare outputs mid-cycle, then advance the model with the same inputs
    task automatic step(string tag);
        logic exp_irq;
        #1;
        chk("R11 feed offer", {31'h0, tx_valid}, {31'h0, m_send});
        if (m_send) chk("R2 offered char", {24'h0, tx_data}, {24'h0, txq[0]});
        exp_irq = (m_ctrl[27] && rxq.size() >= int'(m_lvl[7:0])) ||
                  (m_ctrl[28] && txq.size() <= int'(m_lvl[15:8]));
        chk("R9 R10 irq", {31'h0, irq}, {31'h0, exp_irq});
        if (bus_valid && !bus_write) chk(tag, bus_rdata, exp_read(bus_addr));
        model_update();
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step("");
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        step("");
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(logic [4:0] a, string tag);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        step(tag);
        bus_valid = 0;
    endtask

    task automatic rx_char(logic [7:0] d, logic pe, logic fe);
        rx_valid = 1; rx_data = d; rx_par_err = pe; rx_frm_err = fe;
        step("");
        rx_valid = 0; rx_par_err = 0; rx_frm_err = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
        tx_ready = 0; tx_busy = 0; rx_valid = 0; rx_data = '0;
        rx_par_err = 0; rx_frm_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        rd(5'h0C, "R8 status after reset");
        rd(5'h08, "R1 control after reset");
        // register map and read-back
        wr(5'h10, 32'hABCD_0302);
        rd(5'h10, "R1 levels read-back");
        wr(5'h14, 32'h0081_2345);
        rd(5'h14, "R1 baud read-back");
        rd(5'h00, "R1 transmit offset reads zero");
        rd(5'h1C, "R1 unmapped offset reads zero");
        // transmit in order, with a write landing on a take
        wr(5'h08, 32'h1800_3000);
        rd(5'h08, "R1 control read-back");
        for (int i = 0; i < 5; i++) wr(5'h00, 32'hA0 + i);
        tx_ready = 1;
        wr(5'h00, 32'h55);
        idle(8);
        tx_ready = 0;
        // fill the transmit queue with the feed off
        wr(5'h08, 32'h1800_2000);
        for (int i = 0; i < 66; i++) wr(5'h00, i);
        rd(5'h0C, "R3 full and overwrite flag");
        // held error clear
        wr(5'h08, 32'h1900_2000);
        rd(5'h0C, "R5 errors cleared while held");
        wr(5'h08, 32'h1800_2000);
        wr(5'h00, 32'h99);
        rd(5'h0C, "R3 flag set again after release");
        // full queue: write meets a take in the same cycle
        wr(5'h08, 32'h1800_3000);
        idle(2);
        tx_ready = 1;
        wr(5'h00, 32'h66);
        idle(3);
        tx_ready = 0;
        // transmit reset held
        wr(5'h08, 32'h1840_3000);
        wr(5'h00, 32'h77);
        rd(5'h0C, "R4 transmit queue held empty");
        wr(5'h08, 32'h1800_3000);
        idle(2);
        // receive with errors
        rx_char(8'h11, 0, 0);
        rx_char(8'h22, 1, 0);
        rx_char(8'h33, 0, 1);
        rd(5'h0C, "R6 error flags latched");
        for (int i = 0; i < 4; i++) rd(5'h04, "R7 receive pop");
        rd(5'h0C, "R7 empty read changed nothing");
        wr(5'h08, 32'h1900_3000);
        wr(5'h08, 32'h1800_3000);
        // receive off
        wr(5'h08, 32'h1800_1000);
        rx_char(8'h44, 1, 0);
        rd(5'h0C, "R6 character ignored while off");
        wr(5'h08, 32'h1800_3000);
        // fill the receive queue past full
        for (int i = 0; i < 66; i++) rx_char(8'h80 + i[7:0], 0, 0);
        rd(5'h0C, "R8 receive full status");
        for (int i = 0; i < 68; i++) begin
            bus_valid = 1; bus_write = 0; bus_addr = 5'h04;
            rx_valid = (i % 4 == 0); rx_data = 8'hC0 + i[7:0];
            step("R7 pop with concurrent arrival");
        end
        bus_valid = 0; rx_valid = 0;
        // receive reset held
        rx_char(8'h01, 0, 0);
        rx_char(8'h02, 0, 0);
        wr(5'h08, 32'h1880_3000);
        rx_char(8'h03, 0, 0);
        rd(5'h04, "R4 receive queue held empty");
        rd(5'h0C, "R4 receive status during hold");
        wr(5'h08, 32'h1800_3000);
        // busy mirror
        tx_busy = 1;
        rd(5'h0C, "R8 busy mirrors input");
        tx_busy = 0;
        // clear meets a new error
        wr(5'h08, 32'h1900_3000);
        rx_char(8'h05, 1, 0);
        rd(5'h0C, "R5 clear wins over new error");
        wr(5'h08, 32'h1800_3000);
        rx_char(8'h06, 1, 0);
        rd(5'h0C, "R6 error latches after release");
        // interrupt level sweep
        wr(5'h10, 32'h0000_0004);
        for (int i = 0; i < 4; i++) rx_char(8'h10, 0, 0);
        wr(5'h08, 32'h0800_2000);
        idle(2);
        wr(5'h08, 32'h1000_2000);
        wr(5'h10, 32'h0000_0200);
        for (int i = 0; i < 4; i++) wr(5'h00, i);
        wr(5'h08, 32'h0000_0000);
        idle(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule